// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block turns an asynchronous serial line into characters. The line first passes through a chain of synchronizer flops. A free-running divider then produces sample ticks at 16 or 8 times the bit rate. A small state machine finds the falling edge that opens a frame and decides every bit by a three-sample vote around its centre. The characters it finds go into a short buffer, together with their error flags, until the consumer removes them.

Character length runs from five to nine bits, and a parity bit can follow the data. The receiver checks only the first stop bit and returns to idle at its centre. This leaves it ready for the next frame whatever stop length the sender uses. An address-filter mode drops every character whose top data bit is zero, which lets a node on a shared line ignore data meant for other nodes.

Top module: `uart_rx_recover`

## Requirements
- R1: Sample ticks come every `baud_div`+1 clocks. One bit lasts 16 ticks when `dbl_speed` is 0 and 8 ticks when it is 1, so a bit is 16*(`baud_div`+1) or 8*(`baud_div`+1) clocks long.
- R2: `char_sel` sets the character length: values 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits, and values 4 to 7 give 9. Data arrives least significant bit first. `rx_data` carries data bits 0 to 7, and any bit position above the character length reads 0.
- R3: `rx_bit9` carries data bit 8 of the head character and is 0 for characters shorter than nine bits.
- R4: With `par_en` set, a parity bit follows the last data bit. `par_odd`=0 expects an even number of ones over data plus parity, and `par_odd`=1 expects an odd number. A mismatch sets `rx_par_err` for that character. With `par_en` clear, `rx_par_err` stays 0.
- R5: `rx_frame_err` is set for a character whose first stop bit votes 0. The receiver is idle again from the centre of that stop bit, so a frame that directly follows a second stop bit is received correctly.
- R6: A low level that does not survive to the centre of the start bit (majority of the three middle samples high) is discarded. The receiver returns to idle, produces no character, and receives the next frame correctly.
- R7: Each start, data, parity and stop bit is the majority of three samples at the bit centre, so one corrupted sample does not change the decoded bit.
- R8: With `mp_filter` set, a character whose highest data bit is 0 is discarded and never enters the buffer. A character whose highest data bit is 1 is stored normally.
- R9: The buffer holds two characters. `rx_valid` shows that the head character is present, and a one-cycle `rd_pop` removes it. A character completing while two are held is dropped and sets `rx_overrun`, which clears at the next pop.
- R10: After reset `rx_valid`, `rx_overrun`, `rx_frame_err` and `rx_par_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| baud_div | input | 12 | Sample divisor; tick period is value+1 clocks |
| dbl_speed | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| char_sel | input | 3 | Character length code (R2) |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 odd parity, 0 even parity |
| mp_filter | input | 1 | Address-filter mode (R8) |
| rd_pop | input | 1 | Remove the head character |
| rx_valid | output | 1 | Head character present |
| rx_data | output | 8 | Data bits 0 to 7 of the head character |
| rx_bit9 | output | 1 | Data bit 8 of the head character |
| rx_frame_err | output | 1 | Head character had a bad first stop bit |
| rx_par_err | output | 1 | Head character failed its parity check |
| rx_overrun | output | 1 | A character was lost because the buffer was full |

## Verification
On every cycle the assertions check the buffer's hold behaviour: a present head character stays present and unchanged until it is popped. They also check that an overrun only rises while a character is held, that sample ticks never fall on adjacent cycles when the divisor is non-zero, and that a completed frame is a one-cycle event. Bit decoding cannot be observed cycle by cycle, so only the bench scenarios show it. These scenarios cover character lengths, parity polarity, divisor and speed combinations, start glitches, single-sample spikes, address filtering and the loss of a third character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   localparam int MAX_BITS = 9;

   typedef struct packed {
      logic                frm_err;
      logic                par_err;
      logic [MAX_BITS-1:0] data;
   } rx_char_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("rx_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b1;
            else if (i == 0) chain[i] <= d;
            else chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= div;
      else           cnt <= cnt - 1'b1;
   end
endmodule

// File: rtl/rx_frame.sv
module rx_frame
   import uart_rx_pkg::*;
#(
   parameter int OVS_NORMAL = 16,
   parameter int OVS_DOUBLE = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tick,
   input  logic     line,
   input  logic     dbl,
   input  logic [2:0] char_sel,
   input  logic     par_en,
   input  logic     par_odd,
   output logic     done,
   output rx_char_t chr,
   output logic     top_bit
);
   localparam int SW = $clog2(OVS_NORMAL);

   generate
      if (OVS_DOUBLE < 4 || OVS_NORMAL <= OVS_DOUBLE || (OVS_DOUBLE % 2) != 0 || (OVS_NORMAL % 2) != 0) begin : g_bad
         $error("rx_frame oversampling ratios are inconsistent");
      end
   endgenerate

   rx_state_e           state;
   logic [SW-1:0]       scnt;
   logic [3:0]          bidx;
   logic [MAX_BITS-1:0] data_r;
   logic                pbit_r;
   logic [1:0]          win;

   logic [SW-1:0] s_last, s_pre, s_mid, s_vote;
   logic [3:0]    nbits;
   logic          maj, at_vote, at_last;

   always_comb begin
      s_last  = dbl ? SW'(OVS_DOUBLE-1)   : SW'(OVS_NORMAL-1);
      s_mid   = dbl ? SW'(OVS_DOUBLE/2)   : SW'(OVS_NORMAL/2);
      s_pre   = dbl ? SW'(OVS_DOUBLE/2-1) : SW'(OVS_NORMAL/2-1);
      s_vote  = dbl ? SW'(OVS_DOUBLE/2+1) : SW'(OVS_NORMAL/2+1);
      nbits   = (char_sel >= 3'd4) ? 4'd9 : ({1'b0, char_sel} + 4'd5);
      maj     = (win[1] & win[0]) | (win[1] & line) | (win[0] & line);
      at_vote = (scnt == s_vote);
      at_last = (scnt == s_last);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         scnt    <= '0;
         bidx    <= '0;
         data_r  <= '0;
         pbit_r  <= 1'b0;
         win     <= 2'b11;
         done    <= 1'b0;
         chr     <= '0;
         top_bit <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            if (state == ST_IDLE) begin
               if (!line) begin
                  state  <= ST_START;
                  scnt   <= SW'(1);
                  data_r <= '0;
               end
            end else begin
               scnt <= at_last ? '0 : scnt + 1'b1;
               if (scnt == s_pre || scnt == s_mid) win <= {win[0], line};
               case (state)
                  ST_START: begin
                     if (at_vote && maj) state <= ST_IDLE;
                     else if (at_last) begin
                        state <= ST_DATA;
                        bidx  <= '0;
                     end
                  end
                  ST_DATA: begin
                     if (at_vote) data_r[bidx] <= maj;
                     if (at_last) begin
                        if (bidx == nbits - 4'd1) state <= par_en ? ST_PAR : ST_STOP;
                        else bidx <= bidx + 4'd1;
                     end
                  end
                  ST_PAR: begin
                     if (at_vote) pbit_r <= maj;
                     if (at_last) state <= ST_STOP;
                  end
                  ST_STOP: begin
                     if (at_vote) begin
                        done        <= 1'b1;
                        chr.data    <= data_r;
                        chr.frm_err <= ~maj;
                        chr.par_err <= par_en & ((^data_r ^ pbit_r) != par_odd);
                        top_bit     <= data_r[nbits - 4'd1];
                        state       <= ST_IDLE;
                     end
                  end
                  default: state <= ST_IDLE;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/rx_char_buf.sv
module rx_char_buf #(
   parameter int DEPTH = 2,
   parameter int W     = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1) begin : g_bad
         $error("rx_char_buf depth must be positive");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          do_rd, do_wr;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_rd   = rd_en & ~empty;
   assign do_wr   = wr_en & (~full | do_rd);
   assign rd_data = mem[rp];

   function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
      return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_wr) wp <= nxt(wp);
         if (do_rd) rp <= nxt(rp);
         cnt <= cnt + CW'(do_wr) - CW'(do_rd);
      end
   end
endmodule

// File: rtl/uart_rx_recover.sv
module uart_rx_recover
   import uart_rx_pkg::*;
#(
   parameter int DIV_W       = 12,
   parameter int OVS_NORMAL  = 16,
   parameter int OVS_DOUBLE  = 8,
   parameter int SYNC_STAGES = 2,
   parameter int BUF_DEPTH   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_line,
   input  logic [DIV_W-1:0] baud_div,
   input  logic             dbl_speed,
   input  logic [2:0]       char_sel,
   input  logic             par_en,
   input  logic             par_odd,
   input  logic             mp_filter,
   input  logic             rd_pop,
   output logic             rx_valid,
   output logic [7:0]       rx_data,
   output logic             rx_bit9,
   output logic             rx_frame_err,
   output logic             rx_par_err,
   output logic             rx_overrun
);
   localparam int CHAR_W = $bits(rx_char_t);

   logic     w_line, w_tick, w_push, w_top, w_accept;
   logic     w_empty, w_full;
   rx_char_t w_chr, w_head;
   logic     ovr_r;

   rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rx_line), .q(w_line)
   );

   rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(w_tick)
   );

   rx_frame #(.OVS_NORMAL(OVS_NORMAL), .OVS_DOUBLE(OVS_DOUBLE)) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(w_tick), .line(w_line), .dbl(dbl_speed),
      .char_sel(char_sel), .par_en(par_en), .par_odd(par_odd),
      .done(w_push), .chr(w_chr), .top_bit(w_top)
   );

   assign w_accept = w_push & (~mp_filter | w_top);

   rx_char_buf #(.DEPTH(BUF_DEPTH), .W(CHAR_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(w_accept), .wr_data(w_chr),
      .rd_en(rd_pop), .rd_data(w_head), .empty(w_empty), .full(w_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         ovr_r <= 1'b0;
      else if (w_accept & w_full & ~rd_pop) ovr_r <= 1'b1;
      else if (rd_pop & ~w_empty)         ovr_r <= 1'b0;
   end

   assign rx_valid     = ~w_empty;
   assign rx_data      = w_head.data[7:0];
   assign rx_bit9      = w_head.data[8];
   assign rx_frame_err = w_head.frm_err & ~w_empty;
   assign rx_par_err   = w_head.par_err & ~w_empty;
   assign rx_overrun   = ovr_r;
endmodule

// File: rtl/uart_rx_recover_chk.sv
module uart_rx_recover_chk #(
   parameter int DIV_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_pop,
   input logic             rx_valid,
   input logic [7:0]       rx_data,
   input logic             rx_bit9,
   input logic             rx_overrun,
   input logic [DIV_W-1:0] baud_div,
   input logic             tick,
   input logic             push
);
   // R9: a held character stays until it is popped
   a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !rd_pop |=> rx_valid);

   // R9: the head character does not change while it is not popped
   a_r9_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !rd_pop |=> $stable({rx_data, rx_bit9}));

   // R9: overrun can only appear while characters are held
   a_r9_overrun_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_overrun) |-> $past(rx_valid));

   // R1: with a non-zero divisor no two ticks are adjacent
   a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      tick && baud_div != '0 |=> !tick);

   // R5: a frame completes in a single cycle event
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> !push);
endmodule

bind uart_rx_recover uart_rx_recover_chk #(.DIV_W(DIV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_pop(rd_pop), .rx_valid(rx_valid),
   .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_overrun(rx_overrun),
   .baud_div(baud_div), .tick(w_tick), .push(w_push)
);

// File: tb/uart_rx_recover_tb.sv
module uart_rx_recover_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_line = 1'b1;
   logic [11:0] baud_div = 12'd1;
   logic        dbl_speed = 1'b0;
   logic [2:0]  char_sel = 3'd3;
   logic        par_en = 1'b0;
   logic        par_odd = 1'b0;
   logic        mp_filter = 1'b0;
   logic        rd_pop = 1'b0;
   logic        rx_valid, rx_bit9, rx_frame_err, rx_par_err, rx_overrun;
   logic [7:0]  rx_data;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   uart_rx_recover u_dut (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_div(baud_div),
      .dbl_speed(dbl_speed), .char_sel(char_sel), .par_en(par_en),
      .par_odd(par_odd), .mp_filter(mp_filter), .rd_pop(rd_pop),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_bit9(rx_bit9),
      .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err), .rx_overrun(rx_overrun)
   );

   // fields: div[19:16] dbl[15] len[14:11] pen[10] podd[9] data[8:0]
   localparam logic [19:0] VEC [8] = '{
      {4'd0, 1'b0, 4'd8, 1'b0, 1'b0, 9'h0A5},
      {4'd1, 1'b0, 4'd5, 1'b0, 1'b0, 9'h013},
      {4'd1, 1'b1, 4'd7, 1'b1, 1'b0, 9'h05C},
      {4'd3, 1'b0, 4'd9, 1'b1, 1'b1, 9'h1C3},
      {4'd2, 1'b1, 4'd9, 1'b0, 1'b0, 9'h0FF},
      {4'd1, 1'b0, 4'd6, 1'b1, 1'b1, 9'h03F},
      {4'd0, 1'b1, 4'd8, 1'b1, 1'b0, 9'h100},
      {4'd1, 1'b0, 4'd9, 1'b0, 1'b0, 9'h1FF}
   };

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic set_len(input int n);
      char_sel = (n >= 9) ? 3'd4 : 3'(n - 5);
   endtask

   task automatic drive_bit(input logic v, input bit spike);
      int bp = (dbl_speed ? 8 : 16) * (int'(baud_div) + 1);
      int sw = int'(baud_div) + 1;
      for (int k = 0; k < bp; k++) begin
         @(negedge clk);
         rx_line = (spike && k >= bp/2 && k < bp/2 + sw) ? ~v : v;
      end
   endtask

   // spike_at: sequence index of the bit to corrupt for one sample (0 = start), -1 none
   task automatic send_frame(input logic [8:0] d, input int n, input bit flip_par,
                             input logic stop_v, input int stops, input int spike_at);
      int idx = 0;
      logic pb;
      drive_bit(1'b0, spike_at == idx);
      idx++;
      for (int i = 0; i < n; i++) begin
         drive_bit(d[i], spike_at == idx);
         idx++;
      end
      if (par_en) begin
         pb = 1'b0;
         for (int i = 0; i < n; i++) pb ^= d[i];
         pb = pb ^ par_odd ^ flip_par;
         drive_bit(pb, spike_at == idx);
         idx++;
      end
      drive_bit(stop_v, spike_at == idx);
      for (int s = 1; s < stops; s++) drive_bit(1'b1, 1'b0);
      @(negedge clk);
      rx_line = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic pop;
      @(negedge clk);
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
   endtask

   task automatic idle_bits(input int nb);
      repeat (nb * (dbl_speed ? 8 : 16) * (int'(baud_div) + 1)) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual hung expected finished");
         finish_run();
      end
   end

   logic [19:0] v;
   logic [8:0]  expd;
   int          n;

   initial begin
      repeat (5) @(negedge clk);
      // R10 reset state
      check("R10", "valid in reset", 32'(rx_valid), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R10", "valid", 32'(rx_valid), 0);
      check("R10", "overrun", 32'(rx_overrun), 0);
      check("R10", "frame_err", 32'(rx_frame_err), 0);
      check("R10", "par_err", 32'(rx_par_err), 0);

      // R1 R2 R3 R4 table of lengths, parity, divisors and speeds
      for (int i = 0; i < 8; i++) begin
         v = VEC[i];
         baud_div  = 12'(v[19:16]);
         dbl_speed = v[15];
         n         = int'(v[14:11]);
         set_len(n);
         par_en    = v[10];
         par_odd   = v[9];
         expd      = v[8:0] & 9'((1 << n) - 1);
         idle_bits(2);
         send_frame(v[8:0], n, 1'b0, 1'b1, 1, -1);
         check("R1", "valid", 32'(rx_valid), 1);
         check("R2", "data", 32'(rx_data), 32'(expd[7:0]));
         check("R3", "bit9", 32'(rx_bit9), 32'(expd[8]));
         check("R4", "par_err clean", 32'(rx_par_err), 0);
         check("R5", "frame_err clean", 32'(rx_frame_err), 0);
         pop();
         check("R9", "empty after pop", 32'(rx_valid), 0);
      end

      baud_div = 12'd1; dbl_speed = 1'b0; set_len(8); par_en = 1'b1; par_odd = 1'b0;
      idle_bits(2);
      // R4 wrong even parity
      send_frame(9'h06B, 8, 1'b1, 1'b1, 1, -1);
      check("R4", "par_err even", 32'(rx_par_err), 1);
      check("R4", "data with par err", 32'(rx_data), 32'h6B);
      pop();
      // R4 wrong odd parity
      par_odd = 1'b1;
      send_frame(9'h0F0, 8, 1'b1, 1'b1, 1, -1);
      check("R4", "par_err odd", 32'(rx_par_err), 1);
      pop();
      par_en = 1'b0;

      // R5 stop bit low gives frame error and no second character
      send_frame(9'h05A, 8, 1'b0, 1'b0, 1, -1);
      check("R5", "frame_err", 32'(rx_frame_err), 1);
      check("R5", "data with frame err", 32'(rx_data), 32'h5A);
      idle_bits(3);
      pop();
      check("R5", "single char after bad stop", 32'(rx_valid), 0);

      // R5 two stop bits followed at once by another frame
      send_frame(9'h081, 8, 1'b0, 1'b1, 2, -1);
      send_frame(9'h07E, 8, 1'b0, 1'b1, 1, -1);
      check("R5", "first of pair", 32'(rx_data), 32'h81);
      pop();
      check("R5", "second of pair", 32'(rx_data), 32'h7E);
      check("R5", "second of pair valid", 32'(rx_valid), 1);
      pop();

      // R6 short low pulse is not a start bit
      @(negedge clk); rx_line = 1'b0;
      repeat (6) @(negedge clk);
      rx_line = 1'b1;
      idle_bits(12);
      check("R6", "glitch ignored", 32'(rx_valid), 0);
      send_frame(9'h0C3, 8, 1'b0, 1'b1, 1, -1);
      check("R6", "frame after glitch", 32'(rx_data), 32'hC3);
      pop();

      // R7 one-sample spikes in start, data and stop bits
      send_frame(9'h0A5, 8, 1'b0, 1'b1, 1, 0);
      check("R7", "start spike valid", 32'(rx_valid), 1);
      check("R7", "start spike data", 32'(rx_data), 32'hA5);
      pop();
      send_frame(9'h0A5, 8, 1'b0, 1'b1, 1, 3);
      check("R7", "data spike", 32'(rx_data), 32'hA5);
      pop();
      send_frame(9'h03C, 8, 1'b0, 1'b1, 1, 9);
      check("R7", "stop spike frame_err", 32'(rx_frame_err), 0);
      check("R7", "stop spike data", 32'(rx_data), 32'h3C);
      pop();

      // R8 address filter with nine-bit characters
      mp_filter = 1'b1; set_len(9);
      send_frame(9'h055, 9, 1'b0, 1'b1, 1, -1);
      check("R8", "data char dropped", 32'(rx_valid), 0);
      send_frame(9'h1AA, 9, 1'b0, 1'b1, 1, -1);
      check("R8", "address char kept", 32'(rx_valid), 1);
      check("R8", "address data", 32'(rx_data), 32'hAA);
      check("R8", "address bit9", 32'(rx_bit9), 1);
      pop();
      mp_filter = 1'b0; set_len(8);

      // R9 third character overruns a full buffer
      send_frame(9'h011, 8, 1'b0, 1'b1, 1, -1);
      send_frame(9'h022, 8, 1'b0, 1'b1, 1, -1);
      check("R9", "no overrun at two", 32'(rx_overrun), 0);
      send_frame(9'h033, 8, 1'b0, 1'b1, 1, -1);
      check("R9", "overrun set", 32'(rx_overrun), 1);
      check("R9", "head kept", 32'(rx_data), 32'h11);
      pop();
      check("R9", "overrun cleared", 32'(rx_overrun), 0);
      check("R9", "second char", 32'(rx_data), 32'h22);
      pop();
      check("R9", "third dropped", 32'(rx_valid), 0);

      done = 1'b1;
      finish_run();
   end
endmodule